// File: doc/BRIEF.md
# Posted-Write Register Slave with Ordered Read Responses

This block is the target side of a synchronous, point-to-point core socket. A master presents a request made of a 3-bit command, an address and write data. The request completes on the clock edge where the command is not idle and the slave drives its accept strobe high. Writes are posted: once accepted, they update a small internal register array and never produce a response. Every other accepted command is answered later by a response phase that carries a response code and, for a successful read, the register contents.

Back-pressure is built in. After each accepted request the slave holds its accept strobe low for a fixed number of cycles. It also refuses further read-like requests while its count of unanswered reads is at the limit, and it keeps accepting writes in that state. Responses come out a fixed number of cycles after acceptance, one per cycle at most, in the order the requests were accepted.

Top module: `req_resp_slave`

## Requirements
- R1: After reset, `s_accept` is 1, `s_resp` is 0 and `s_rdata` is 0, and every register reads as zero.
- R2: A request completes only on a clock edge where `m_cmd` is non-zero and `s_accept` is 1. An idle command (0) completes nothing and leaves `s_accept` high when no stall is pending.
- R3: After every completed request, `s_accept` stays low for `STALL_CYC` cycles and rises in the cycle after that.
- R4: Command 1 is a write. When the address is below `NREG` it stores `m_wdata` in register `m_addr`. A write never produces a response, so `s_resp` stays 0 for it.
- R5: Command 2 is a read. When it completes in cycle c with an address below `NREG`, `s_resp` is 1 (data valid) and `s_rdata` holds the register value for exactly cycle c+`RESP_LAT`.
- R6: A read at an address of `NREG` or more is answered with code 3 (error) and zero data. A write at such an address is accepted and changes no register.
- R7: Commands 3 to 7 are unsupported. They are accepted like reads, are answered with code 3 at the read latency, and change no register.
- R8: Responses appear in the order in which their requests completed.
- R9: At most `MAX_OUT` read-like requests are unanswered at any time. While that limit is reached, `s_accept` is low for commands 2 to 7 and is still high for writes. A read's slot stays occupied until the end of the cycle in which its response is shown.
- R10: `s_resp` only ever takes the values 0, 1 or 3, and `s_rdata` is 0 in every cycle where `s_resp` is not 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every signal is sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| m_cmd | input | 3 | Request command: 0 idle, 1 write, 2 read, 3-7 unsupported |
| m_addr | input | ADDR_W | Register address of the request |
| m_wdata | input | DATA_W | Write data |
| s_accept | output | 1 | Slave accepts the current request |
| s_resp | output | 3 | Response code: 0 none, 1 data valid, 3 error |
| s_rdata | output | DATA_W | Read data, valid when `s_resp` is 1 |

## Verification
Corrupted state in the register array shows up as wrong `s_rdata` on the first read of the damaged entry, exactly `RESP_LAT` cycles after that read is accepted. A fault in the latency pipeline or the outstanding counter shows up at once as a response in the wrong cycle, a missing or extra response, or an accept strobe that disagrees with the expected accept cycle of the next read. A fault in the stall counter moves the accept cycle of a back-to-back request by one cycle or more, and the response order check exposes any mix-up of queued entries when the first affected response comes out.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
    localparam logic [2:0] CMD_IDLE = 3'd0;
    localparam logic [2:0] CMD_WR   = 3'd1;
    localparam logic [2:0] CMD_RD   = 3'd2;

    localparam logic [2:0] RSP_NONE = 3'd0;
    localparam logic [2:0] RSP_DATA = 3'd1;
    localparam logic [2:0] RSP_ERR  = 3'd3;

    // Any non-idle command other than a write expects a response.
    function automatic logic wants_resp(input logic [2:0] cmd);
        return (cmd != CMD_IDLE) && (cmd != CMD_WR);
    endfunction
endpackage

// File: rtl/rrs_regbank.sv
module rrs_regbank #(
    parameter int NREG   = 8,
    parameter int DATA_W = 32,
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] word;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NREG; i++) begin
            if (wr_en && (32'(wr_idx) == i)) begin
                bank_d.word[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign rd_data = bank_q.word[rd_idx];
endmodule

// File: rtl/rrs_throttle.sv
module rrs_throttle #(
    parameter int STALL_CYC = 1,
    localparam int CNT_W = $clog2(STALL_CYC + 2)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic open
);
    typedef struct packed {
        logic [CNT_W-1:0] left;
    } thr_t;

    thr_t thr_d, thr_q;

    always_comb begin
        thr_d = thr_q;
        if (fire) begin
            thr_d.left = CNT_W'(STALL_CYC);
        end else if (thr_q.left != '0) begin
            thr_d.left = thr_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) thr_q <= '0;
        else        thr_q <= thr_d;
    end

    assign open = (thr_q.left == '0);
endmodule

// File: rtl/rrs_resp_pipe.sv
module rrs_resp_pipe #(
    parameter int RESP_LAT = 4,
    parameter int MAX_OUT  = 2,
    parameter int DATA_W   = 32,
    localparam int OCW = $clog2(MAX_OUT + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [2:0]        push_code,
    input  logic [DATA_W-1:0] push_data,
    output logic [2:0]        out_code,
    output logic [DATA_W-1:0] out_data,
    output logic              full
);
    import rrs_pkg::*;

    typedef struct packed {
        logic              vld;
        logic [2:0]        code;
        logic [DATA_W-1:0] data;
    } slot_t;

    typedef struct packed {
        slot_t [RESP_LAT-1:0] stg;
        logic  [OCW-1:0]      pend;
    } pipe_t;

    pipe_t pipe_d, pipe_q;
    slot_t head;

    assign head = pipe_q.stg[RESP_LAT-1];

    always_comb begin
        pipe_d = pipe_q;
        pipe_d.stg[0].vld  = push;
        pipe_d.stg[0].code = push ? push_code : RSP_NONE;
        pipe_d.stg[0].data = push ? push_data : '0;
        for (int i = 1; i < RESP_LAT; i++) begin
            pipe_d.stg[i] = pipe_q.stg[i-1];
        end
        pipe_d.pend = pipe_q.pend + OCW'(push) - OCW'(head.vld);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign full     = (pipe_q.pend >= OCW'(MAX_OUT));
    assign out_code = head.vld ? head.code : RSP_NONE;
    assign out_data = (head.vld && head.code == RSP_DATA) ? head.data : '0;
endmodule

// File: rtl/req_resp_slave.sv
module req_resp_slave #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int NREG      = 8,
    parameter int RESP_LAT  = 4,
    parameter int STALL_CYC = 1,
    parameter int MAX_OUT   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        m_cmd,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic [DATA_W-1:0] m_wdata,
    output logic              s_accept,
    output logic [2:0]        s_resp,
    output logic [DATA_W-1:0] s_rdata
);
    import rrs_pkg::*;

    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

    logic              open, full, fire, in_range, rd_like;
    logic              wr_en, push;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] bank_rd;
    logic [2:0]        push_code;
    logic [DATA_W-1:0] push_data;

    assign rd_like  = wants_resp(m_cmd);
    assign in_range = ({1'b0, m_addr} < (ADDR_W+1)'(NREG));
    assign idx      = IDX_W'(m_addr);

    assign s_accept = open && !(rd_like && full);
    assign fire     = s_accept && (m_cmd != CMD_IDLE);

    assign wr_en     = fire && (m_cmd == CMD_WR) && in_range;
    assign push      = fire && rd_like;
    assign push_code = ((m_cmd == CMD_RD) && in_range) ? RSP_DATA : RSP_ERR;
    assign push_data = (push_code == RSP_DATA) ? bank_rd : '0;

    rrs_throttle #(.STALL_CYC(STALL_CYC)) u_thr (
        .clk  (clk),
        .rst_n(rst_n),
        .fire (fire),
        .open (open)
    );

    rrs_regbank #(.NREG(NREG), .DATA_W(DATA_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (idx),
        .wr_data(m_wdata),
        .rd_idx (idx),
        .rd_data(bank_rd)
    );

    rrs_resp_pipe #(.RESP_LAT(RESP_LAT), .MAX_OUT(MAX_OUT), .DATA_W(DATA_W)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_code(push_code),
        .push_data(push_data),
        .out_code (s_resp),
        .out_data (s_rdata),
        .full     (full)
    );
endmodule

// File: rtl/rrs_checker.sv
module rrs_checker #(
    parameter int DATA_W    = 32,
    parameter int STALL_CYC = 1,
    parameter int MAX_OUT   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        m_cmd,
    input logic              s_accept,
    input logic [2:0]        s_resp,
    input logic [DATA_W-1:0] s_rdata
);
    logic [7:0] owed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) owed_q <= '0;
        else owed_q <= owed_q + 8'(s_accept && (m_cmd > 3'd1)) - 8'(s_resp != 3'd0);
    end

    generate
        if (STALL_CYC > 0) begin : g_stall
            a_r3_stall_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
                (m_cmd != 3'd0 && s_accept) |=> !s_accept);
        end
    endgenerate

    a_r2_idle_keeps_open: assert property (@(posedge clk) disable iff (!rst_n)
        (m_cmd == 3'd0 && s_accept) |=> (s_accept || m_cmd > 3'd1));

    a_r10_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (s_resp == 3'd0 || s_resp == 3'd1 || s_resp == 3'd3));

    a_r10_rdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (s_resp != 3'd1) |-> (s_rdata == '0));

    a_r9_outstanding_limit: assert property (@(posedge clk) disable iff (!rst_n)
        owed_q <= 8'(MAX_OUT));

    a_r4_resp_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        (s_resp != 3'd0) |-> (owed_q != 8'd0));
endmodule

bind req_resp_slave rrs_checker #(
    .DATA_W(DATA_W), .STALL_CYC(STALL_CYC), .MAX_OUT(MAX_OUT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .m_cmd(m_cmd), .s_accept(s_accept),
    .s_resp(s_resp), .s_rdata(s_rdata)
);

// File: tb/tb_req_resp_slave.sv
module tb_req_resp_slave;
    localparam int LAT = 4, STALL = 1, MAXO = 2, NREG = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  m_cmd = 3'd0;
    logic [7:0]  m_addr = '0;
    logic [31:0] m_wdata = '0;
    logic        s_accept;
    logic [2:0]  s_resp;
    logic [31:0] s_rdata;

    always #5 clk = ~clk;

    req_resp_slave #(.ADDR_W(8), .DATA_W(32), .NREG(NREG), .RESP_LAT(LAT),
                     .STALL_CYC(STALL), .MAX_OUT(MAXO)) dut (
        .clk(clk), .rst_n(rst_n), .m_cmd(m_cmd), .m_addr(m_addr), .m_wdata(m_wdata),
        .s_accept(s_accept), .s_resp(s_resp), .s_rdata(s_rdata));

    int errors = 0, checks = 0, cyc = 0;
    bit done = 0;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected response queue
    int          e_due [64];
    logic [2:0]  e_code[64];
    logic [31:0] e_data[64];
    int head = 0, tail = 0;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (head < tail && e_due[head] < cyc) begin
                check(0, "R8 response missed", 64'(cyc), 64'(e_due[head]));
                head++;
            end else if (head < tail && e_due[head] == cyc) begin
                check(s_resp == e_code[head], "R5/R8 response code", 64'(s_resp), 64'(e_code[head]));
                check(s_rdata == e_data[head], "R5/R10 response data", 64'(s_rdata), 64'(e_data[head]));
                head++;
            end else begin
                check(s_resp == 3'd0 && s_rdata == '0, "R4/R10 no response expected",
                      {29'd0, s_resp, s_rdata}, 64'd0);
            end
        end
    end

    task automatic req(input logic [2:0] c, input logic [7:0] a, input logic [31:0] wd,
                       input logic [2:0] ec, input logic [31:0] ed,
                       output int att, output int acc);
        @(negedge clk);
        m_cmd = c; m_addr = a; m_wdata = wd;
        att = cyc;
        #1;
        while (!s_accept) begin
            @(negedge clk);
            #1;
        end
        acc = cyc;
        if (c > 3'd1) begin
            e_due[tail] = acc + LAT; e_code[tail] = ec; e_data[tail] = ed;
            tail++;
        end
        @(posedge clk);
    endtask

    task automatic go_idle(input int n);
        @(negedge clk);
        m_cmd = 3'd0;
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        @(negedge clk);
        m_cmd = 3'd0;
        while (head < tail) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    typedef struct packed {
        logic [2:0]  cmd;
        logic [7:0]  addr;
        logic [31:0] wd;
        logic [2:0]  ecode;
        logic [31:0] edata;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{3'd1, 8'd1,  32'h11110001, 3'd0, 32'h0},          // R4 write
        '{3'd1, 8'd7,  32'hA5A5A5A5, 3'd0, 32'h0},          // R4 write
        '{3'd2, 8'd1,  32'h0,        3'd1, 32'h11110001},   // R5 read
        '{3'd2, 8'd7,  32'h0,        3'd1, 32'hA5A5A5A5},   // R5 read
        '{3'd2, 8'd3,  32'h0,        3'd1, 32'h0},          // R1 reset value
        '{3'd1, 8'd9,  32'hDEADBEEF, 3'd0, 32'h0},          // R6 write out of range
        '{3'd2, 8'd1,  32'h0,        3'd1, 32'h11110001},   // R6 alias unchanged
        '{3'd2, 8'd9,  32'h0,        3'd3, 32'h0},          // R6 read out of range
        '{3'd5, 8'd3,  32'h12345678, 3'd3, 32'h0},          // R7 unsupported
        '{3'd2, 8'd3,  32'h0,        3'd1, 32'h0},          // R7 no register change
        '{3'd3, 8'd0,  32'h0,        3'd3, 32'h0},          // R7 unsupported
        '{3'd1, 8'd0,  32'hCAFEF00D, 3'd0, 32'h0},          // R4 write
        '{3'd2, 8'd0,  32'h0,        3'd1, 32'hCAFEF00D},   // R5 read
        '{3'd7, 8'd0,  32'hFF,       3'd3, 32'h0},          // R7 unsupported
        '{3'd2, 8'd0,  32'h0,        3'd1, 32'hCAFEF00D}    // R7/R8 order
    };

    initial begin
        int a1, c1, a2, c2, a3, c3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(s_accept == 1'b1, "R1 accept after reset", 64'(s_accept), 64'd1);
        check(s_resp == 3'd0, "R1 resp after reset", 64'(s_resp), 64'd0);
        check(s_rdata == '0, "R1 rdata after reset", 64'(s_rdata), 64'd0);

        for (int i = 0; i < NV; i++) begin
            req(VEC[i].cmd, VEC[i].addr, VEC[i].wd, VEC[i].ecode, VEC[i].edata, a1, c1);
        end
        drain();

        // R3: back-to-back writes, second waits STALL cycles
        req(3'd1, 8'd2, 32'h2, 3'd0, 32'h0, a1, c1);
        req(3'd1, 8'd2, 32'h22, 3'd0, 32'h0, a2, c2);
        check(a2 == c1 + 1, "R3 second attempt next cycle", 64'(a2), 64'(c1 + 1));
        check(c2 == c1 + STALL + 1, "R3 accept after stall", 64'(c2), 64'(c1 + STALL + 1));
        go_idle(3);
        // R2: idle cycles leave the slave open, the request goes through at once
        req(3'd2, 8'd2, 32'h0, 3'd1, 32'h22, a3, c3);
        check(c3 == a3, "R2 immediate accept after idle", 64'(c3), 64'(a3));
        drain();

        // R9: third read waits for the first response (LAT=4, STALL=1, MAXO=2)
        req(3'd2, 8'd2, 32'h0, 3'd1, 32'h22, a1, c1);
        req(3'd2, 8'd7, 32'h0, 3'd1, 32'hA5A5A5A5, a2, c2);
        req(3'd2, 8'd0, 32'h0, 3'd1, 32'hCAFEF00D, a3, c3);
        check(c2 == c1 + 2, "R9 second read accept", 64'(c2), 64'(c1 + 2));
        check(c3 == c1 + 5, "R9 third read held while full", 64'(c3), 64'(c1 + 5));
        drain();

        // R9: a write is not blocked while reads are at the limit
        req(3'd2, 8'd1, 32'h0, 3'd1, 32'h11110001, a1, c1);
        req(3'd4, 8'd1, 32'h0, 3'd3, 32'h0, a2, c2);
        req(3'd1, 8'd5, 32'h55, 3'd0, 32'h0, a3, c3);
        check(c3 == c1 + 4, "R9 write accepted while full", 64'(c3), 64'(c1 + 4));
        req(3'd2, 8'd5, 32'h0, 3'd1, 32'h55, a1, c1);
        drain();

        done = 1;
        report();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL R2 watchdog actual=hung expected=complete");
            report();
            $finish;
        end
    end
endmodule